// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for Clause 22 management frames on an MDC/MDIO pair. Software waits for the busy flag to clear, then writes one command word. That word holds a valid flag, a read or write selector, the PHY and register addresses and, for writes, 16 data bits. The controller then builds and shifts out the whole frame by itself. A frame is 32 preamble ones, the start pattern, the opcode, both 5-bit addresses sent MSB first, the turnaround and 16 data bits.

For a read, the controller releases MDIO at the turnaround and checks that the PHY pulls the line low in the second turnaround bit. It then shifts in 16 bits. The result, with a 2-bit error code, is held in the data register. MDC comes from the system clock through a counter. It toggles every `MDC_HALF` system cycles and stays low between frames.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x0 (status), 0x8 (command) and 0xC (data). Any other offset reads 0. After reset the status and data registers read 0, MDC is low and `mdio_oe` is low.
- R2: Status bit 3 (busy) reads 1 in the cycle after a command is accepted. It stays 1 until the frame's last data bit ends, then returns to 0.
- R3: A command write with bit 31 clear starts nothing.
- R4: Command bit 1 requests a write and bit 2 requests a read. A command with both bits set or with neither set is dropped.
- R5: A frame is 32 ones, `01`, an opcode (`10` read, `01` write), PHY address (command bits 29:25), register address (bits 24:20), turnaround `10` and write data (bits 19:4). Every field goes out MSB first.
- R6: `mdio_oe` is high for all 64 bits of a write. For a read it is high for the first 46 bits only. It is low whenever the controller is idle.
- R7: After a read, data register bits 15:0 hold the 16 bits sampled from `mdio_i`, MSB first, and bits 17:16 read `00`.
- R8: If `mdio_i` is high when sampled in the second turnaround bit of a read, data bits 17:16 read `10`.
- R9: MDC has a period of 2×`MDC_HALF` system clocks. `mdio_o` changes only as MDC falls, and `mdio_i` is sampled as MDC rises.
- R10: A command written while busy is set is dropped and does not disturb the frame in progress.
- R11: Command bits 0 and 3 have no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with `MDC_HALF` = 2 and the default 32-bit preamble. A whole frame therefore takes 256 system cycles, so every frame bit, both turnaround samples and the end of busy can be watched in a short run. The small divider also makes the MDC period easy to measure in the bench. It places a command written during busy inside the same frame that is being traced.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int MDC_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FLEN    = PRE_LEN + 32;
  localparam int CW      = $clog2(FLEN + 1);
  localparam int DW      = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam int DRV_END = PRE_LEN + 14;
  localparam int TA2     = PRE_LEN + 15;

  logic            busy, mdc_q, is_read, ta_err;
  logic [CW-1:0]   bitcnt;
  logic [DW-1:0]   divcnt;
  logic [FLEN-1:0] shreg;
  logic [15:0]     rd_q;

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{reg_wdata[30], reg_wdata[3], reg_wdata[0]};

  wire accept = reg_wr && reg_addr == 4'h8 && reg_wdata[31] &&
                (reg_wdata[1] ^ reg_wdata[2]) && !busy;
  wire tick   = busy && divcnt == DW'(MDC_HALF - 1);
  wire rise   = tick && !mdc_q;
  wire fall   = tick && mdc_q;
  wire last   = bitcnt == CW'(FLEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mdc_q   <= 1'b0;
      is_read <= 1'b0;
      ta_err  <= 1'b0;
      bitcnt  <= '0;
      divcnt  <= '0;
      shreg   <= '0;
      rd_q    <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      mdc_q   <= 1'b0;
      is_read <= reg_wdata[2];
      bitcnt  <= '0;
      divcnt  <= '0;
      shreg   <= {{PRE_LEN{1'b1}}, 2'b01, reg_wdata[2] ? 2'b10 : 2'b01,
                  reg_wdata[29:25], reg_wdata[24:20], 2'b10, reg_wdata[19:4]};
      if (reg_wdata[2]) begin
        rd_q   <= '0;
        ta_err <= 1'b0;
      end
    end else if (busy) begin
      divcnt <= tick ? '0 : divcnt + 1'b1;
      if (tick) mdc_q <= ~mdc_q;
      if (rise && is_read) begin
        if (bitcnt == CW'(TA2)) ta_err <= mdio_i;
        if (bitcnt > CW'(TA2))  rd_q   <= {rd_q[14:0], mdio_i};
      end
      if (fall) begin
        if (last) begin
          busy <= 1'b0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          shreg  <= shreg << 1;
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = shreg[FLEN-1];
  assign mdio_oe = busy && (!is_read || bitcnt < CW'(DRV_END));

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = {28'd0, busy, 3'd0};
      4'hC:    reg_rdata = {14'd0, ta_err, 1'b0, rd_q};
      default: reg_rdata = '0;
    endcase
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r2_busy_ends_on_last_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last) && $fell(mdc_q));
  a_r3_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == 4'h8 && !reg_wdata[31]) |=> !busy);
  a_r4_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == 4'h8 && (reg_wdata[1] == reg_wdata[2])) |=> !busy);
  a_r9_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc_q));
  a_r9_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(bitcnt)) |-> $fell(mdc_q) && bitcnt == $past(bitcnt) + 1'b1);
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
  localparam int HALF = 2;

  logic        clk = 0, rst_n = 0, reg_wr = 0, mdio_i = 1;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0, failures = 0, frames_seen = 0;
  realtime t_r0, t_r1;

  typedef struct packed {
    logic [63:0] bits;
    logic [63:0] oe;
    logic        rd;
    logic        ta_fail;
    logic [15:0] resp;
  } exp_t;
  exp_t expq[$];

  mdio_mgmt_ctrl #(.MDC_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit rd, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    return {1'b1, 1'b0, phy, ra, wd, 1'b0, rd, !rd, 1'b0};
  endfunction

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      reg_read(4'h0, s);
      if (!s[3]) break;
    end
  endtask

  task automatic issue(input logic [31:0] cmd, input logic [15:0] resp, input bit ta_fail);
    exp_t e;
    e.rd = cmd[2];
    e.bits = {32'hFFFF_FFFF, 2'b01, cmd[2] ? 2'b10 : 2'b01, cmd[29:25], cmd[24:20], 2'b10, cmd[19:4]};
    e.oe = cmd[2] ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    e.ta_fail = ta_fail;
    e.resp = resp;
    expq.push_back(e);
    reg_write(4'h8, cmd);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      logic [63:0] ob, oo;
      @(posedge mdio_oe);
      frames_seen++;
      if (expq.size() == 0) begin
        check(0, "R10 unexpected frame", 64'd1, 64'd0);
        e = '0;
      end else e = expq.pop_front();
      for (int k = 0; k < 64; k++) begin
        @(posedge mdc);
        if (k == 0) t_r0 = $realtime;
        if (k == 1) t_r1 = $realtime;
        ob[63-k] = mdio_o;
        oo[63-k] = mdio_oe;
        if (k < 63) begin
          @(negedge mdc);
          if (e.rd && k + 1 == 47) mdio_i = e.ta_fail;
          else if (e.rd && k + 1 >= 48) mdio_i = e.resp[63-(k+1)];
          else mdio_i = 1'b1;
        end
      end
      @(negedge mdc);
      mdio_i = 1'b1;
      check((ob & e.oe) == (e.bits & e.oe), "R5 frame bits", ob & e.oe, e.bits & e.oe);
      check(oo == e.oe, "R6 output enable pattern", oo, e.oe);
      check(t_r1 - t_r0 == 2 * HALF * 10, "R9 mdc period", 64'(int'(t_r1 - t_r0)), 64'(2 * HALF * 10));
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    logic [31:0] s, d;
    int f0;
    repeat (3) @(negedge clk);
    reg_read(4'h0, s); check(s == 0, "R1 status reset", s, 0);
    reg_read(4'hC, d); check(d == 0, "R1 data reset", d, 0);
    check(mdc == 0 && mdio_oe == 0, "R1 pins reset", {mdc, mdio_oe}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    issue(mk(0, 5'd5, 5'h1A, 16'hA5C3), 0, 0);
    reg_read(4'h0, s); check(s[3] == 1, "R2 busy after accept", s, 8);
    wait_idle();
    reg_read(4'h0, s); check(s == 0, "R2 busy clears", s, 0);
    check(mdc == 0 && mdio_oe == 0, "R6 R9 idle pins", {mdc, mdio_oe}, 0);

    issue(mk(1, 5'h1F, 5'd3, 16'h0), 16'h1234, 0);
    wait_idle();
    reg_read(4'hC, d); check(d == 32'h0000_1234, "R7 read data", d, 32'h1234);

    issue(mk(1, 5'd1, 5'd2, 16'h0), 16'hBEEF, 1);
    wait_idle();
    reg_read(4'hC, d); check(d[17:16] == 2'b10, "R8 error code", d[17:16], 2'b10);

    issue(mk(1, 5'd9, 5'h11, 16'h0), 16'h8001, 0);
    wait_idle();
    reg_read(4'hC, d); check(d == 32'h0000_8001, "R7 read data edges", d, 32'h8001);

    f0 = frames_seen;
    reg_write(4'h8, mk(0, 5'd2, 5'd2, 16'h1111) & 32'h7FFF_FFFF);
    repeat (20) @(negedge clk);
    reg_read(4'h0, s);
    check(s == 0 && frames_seen == f0, "R3 no valid bit", {s, 32'(frames_seen - f0)}, 0);

    reg_write(4'h8, mk(0, 5'd2, 5'd2, 16'h1111) | 32'h4);
    repeat (20) @(negedge clk);
    reg_read(4'h0, s);
    check(s == 0 && frames_seen == f0, "R4 both op bits", {s, 32'(frames_seen - f0)}, 0);
    reg_write(4'h8, mk(0, 5'd2, 5'd2, 16'h1111) & ~32'h6);
    repeat (20) @(negedge clk);
    reg_read(4'h0, s);
    check(s == 0 && frames_seen == f0, "R4 no op bits", {s, 32'(frames_seen - f0)}, 0);

    issue(mk(0, 5'd7, 5'd4, 16'h5A5A), 0, 0);
    repeat (30) @(negedge clk);
    reg_write(4'h8, mk(1, 5'd3, 5'd3, 16'h0));
    wait_idle();
    repeat (300) @(negedge clk);
    reg_read(4'hC, d);
    check(frames_seen == f0 + 1 && d == 32'h8001, "R10 command while busy dropped",
          {32'(frames_seen - f0), d}, {32'd1, 32'h8001});

    issue(mk(0, 5'h10, 5'h1F, 16'hFFFF) | 32'h9, 0, 0);
    wait_idle();
    check(frames_seen == f0 + 2, "R11 scan bits ignored", 32'(frames_seen - f0), 2);

    reg_read(4'h4, d); check(d == 0, "R1 unmapped offset", d, 0);
    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R5 all frames seen", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule